// File: doc/BRIEF.md
# Oscillator Configuration Matching Controller

This controller closes the loop around a coherent-sampling entropy source. Each time the beat counter finishes one measurement it raises a request strobe for one clock together with the measured count. The controller tests the count against a fixed acceptance band and groups incoming measurements into windows of 128. A measurement inside the band raises the matched flag at once. When a complete window goes by without a single measurement inside the band, the controller moves the configurable oscillator on to its next selection word and drops the matched flag.

The selection word carries two bits per configurable oscillator stage. After its largest value it returns to zero, so the search keeps cycling through every configuration. The band limits, the number of stages and the window length are parameters.

Measurements enter as a stream. The request strobe acts as the valid signal, and the block accepts a measurement on every clock in which the strobe is high. The block never applies back-pressure, so the source needs no ready signal and must not wait for one. The selection word and the matched flag are plain registered outputs.

Top module: `osc_match_ctrl`

## Requirements
- R1: After reset the selection word is 0, the matched flag is 0, and both the window position and the in-band tally are 0.
- R2: In a cycle with the request strobe low, no state changes, whatever the count input carries.
- R3: A count is in band when LO_BOUND <= count < HI_BOUND. The lower limit is inside the band and the upper limit is outside it.
- R4: An in-band measurement sets the matched flag to 1 on the next clock.
- R5: A window ends on the measurement accepted while the window position is 127, which is the 128th measurement of the window.
- R6: At the end of a window, if the in-band tally is zero, the selection word increases by one on the next clock and the matched flag is cleared. At no other time does the selection word change.
- R7: The in-band tally returns to zero at the end of every window, so a window that follows a good window is judged on its own measurements.
- R8: The window position advances by one for each accepted measurement only, and goes from 127 back to 0.
- R9: The selection word is 2*STAGES bits wide and goes from its maximum value back to 0.
- R10: The zero test at the end of a window uses the tally from before the final measurement is counted. If that final measurement is in band, the word still steps and the matched flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Measurement valid strobe, one cycle per measurement |
| beat_cnt_i | input | CNT_W | Measured beat count |
| osc_sel_o | output | 2*STAGES | Oscillator configuration selection word |
| matched_o | output | 1 | An in-band measurement has been seen since the last unproductive window |

## Verification
The case that is hardest to reach from the ports is the wrap of the selection word. It only happens after 256 consecutive windows that contain no in-band measurement, which is 32768 accepted measurements. The bench reaches it by streaming out-of-band counts back to back until the word reaches its maximum, then sending one more dry window. A second case that is hard to hit is a window whose only in-band measurement is its last one. The bench builds it by counting measurements exactly, so that the lower-limit value lands on window position 127.

// File: rtl/osc_match_pkg.sv
package osc_match_pkg;

  // End-of-window status passed from the window tracker to the stepper
  typedef struct packed {
    logic last;  // current window position is the final one
    logic dry;   // no in-band measurement counted so far in this window
  } win_stat_t;

endpackage

// File: rtl/osc_match_band.sv
module osc_match_band #(
  parameter int CNT_W    = 12,
  parameter int LO_BOUND = 40,
  parameter int HI_BOUND = 60
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic             in_band_o
);
  localparam logic [CNT_W-1:0] LoVal = CNT_W'(LO_BOUND);
  localparam logic [CNT_W-1:0] HiVal = CNT_W'(HI_BOUND);

  always_comb begin
    in_band_o = (cnt_i >= LoVal) && (cnt_i < HiVal);
  end
endmodule

// File: rtl/osc_match_window.sv
module osc_match_window
  import osc_match_pkg::*;
#(
  parameter int WIN_LOG2 = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_i,
  input  logic      good_i,
  output win_stat_t stat_o
);
  localparam logic [WIN_LOG2-1:0] PosMax = {WIN_LOG2{1'b1}};

  logic [WIN_LOG2-1:0] pos_q;
  logic [WIN_LOG2-1:0] tally_q;

  always_comb begin
    stat_o.last = (pos_q == PosMax);
    stat_o.dry  = (tally_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      tally_q <= '0;
    end else if (req_i) begin
      pos_q <= pos_q + 1'b1;
      if (stat_o.last) tally_q <= '0;
      else             tally_q <= tally_q + WIN_LOG2'(good_i);
    end
  end

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && stat_o.last) |=> (pos_q == '0)); // R8
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(pos_q) && $stable(tally_q)); // R2
  AST_TALLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && stat_o.last) |=> stat_o.dry); // R7
endmodule

// File: rtl/osc_match_step.sv
module osc_match_step
  import osc_match_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             good_i,
  input  win_stat_t        stat_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             matched_o
);
  logic advance;

  always_comb begin
    advance = req_i && stat_i.last && stat_i.dry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o     <= '0;
      matched_o <= 1'b0;
    end else if (req_i) begin
      if (advance) sel_o <= sel_o + 1'b1;
      if (good_i)       matched_o <= 1'b1;
      else if (advance) matched_o <= 1'b0;
    end
  end

  AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && good_i) |=> matched_o); // R4
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> $stable(sel_o) && $stable(matched_o)); // R2
  AST_SEL_MIDWIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !stat_i.last) |=> $stable(sel_o)); // R6
  AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && stat_i.last && stat_i.dry) |=> (sel_o == $past(sel_o) + 1'b1)); // R6
endmodule

// File: rtl/osc_match_ctrl.sv
module osc_match_ctrl
  import osc_match_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int LO_BOUND = 40,
  parameter int HI_BOUND = 60,
  parameter int STAGES   = 4,
  parameter int WIN_LOG2 = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_i,
  input  logic [CNT_W-1:0]      beat_cnt_i,
  output logic [2*STAGES-1:0]   osc_sel_o,
  output logic                  matched_o
);
  localparam int SelW = 2 * STAGES;

  logic      good;
  win_stat_t stat;

  osc_match_band #(
    .CNT_W(CNT_W), .LO_BOUND(LO_BOUND), .HI_BOUND(HI_BOUND)
  ) u_band (
    .cnt_i(beat_cnt_i), .in_band_o(good)
  );

  osc_match_window #(.WIN_LOG2(WIN_LOG2)) u_window (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .good_i(good), .stat_o(stat)
  );

  osc_match_step #(.SEL_W(SelW)) u_step (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .good_i(good), .stat_i(stat),
    .sel_o(osc_sel_o), .matched_o(matched_o)
  );

  AST_BAND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && beat_cnt_i == CNT_W'(LO_BOUND)) |=> matched_o); // R3
endmodule

// File: tb/osc_match_ctrl_bench.sv
module osc_match_ctrl_bench;
  localparam int CNT_W = 12;
  localparam int LO = 40;
  localparam int HI = 60;
  localparam int STAGES = 4;
  localparam int SW = 2 * STAGES;
  localparam int WLEN = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [CNT_W-1:0] beat = '0;
  logic [SW-1:0] sel;
  logic matched;

  int n_chk = 0;
  int n_fail = 0;
  int m_sel = 0, m_pos = 0, m_tally = 0;
  bit m_match = 0;

  always #2 clk = ~clk;

  osc_match_ctrl #(.CNT_W(CNT_W), .LO_BOUND(LO), .HI_BOUND(HI), .STAGES(STAGES))
    u_osc_match_ctrl (.clk(clk), .rst_n(rst_n), .req_i(req), .beat_cnt_i(beat),
                      .osc_sel_o(sel), .matched_o(matched));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one accepted measurement; entered and left at a falling edge
  task automatic send(input int v);
    bit g, last;
    req = 1'b1; beat = CNT_W'(v);
    @(negedge clk);
    req = 1'b0;
    g = (v >= LO) && (v < HI);
    last = (m_pos == WLEN - 1);
    if (last && m_tally == 0) begin
      m_sel = (m_sel + 1) % (1 << SW);
      m_match = g;
    end else if (g) m_match = 1;
    m_tally = last ? 0 : m_tally + int'(g);
    m_pos = (m_pos + 1) % WLEN;
  endtask

  task automatic send_n(input int v, input int n);
    for (int i = 0; i < n; i++) send(v);
  endtask

  task automatic t_reset();
    chk("R1 sel after reset", int'(sel), 0);
    chk("R1 matched after reset", int'(matched), 0);
  endtask

  task automatic t_idle();
    beat = CNT_W'(LO + 1);
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk("R2 sel idle", int'(sel), 0);
    chk("R2 matched idle", int'(matched), 0);
  endtask

  task automatic t_dry_window();
    send_n(HI, WLEN - 1);
    chk("R5 sel before window end", int'(sel), 0);
    send(HI);
    chk("R6 sel after dry window", int'(sel), 1);
    chk("R3 upper bound excluded", int'(matched), 0);
  endtask

  task automatic t_last_good();
    send_n(LO - 1, WLEN - 1);
    chk("R3 below lower bound", int'(matched), 0);
    send(LO);
    chk("R10 sel steps on good last", int'(sel), 2);
    chk("R10 matched after good last", int'(matched), 1);
  endtask

  task automatic t_good_window();
    send(HI - 1);
    chk("R4 matched on good", int'(matched), 1);
    send_n(0, 60);
    req = 1'b0; beat = CNT_W'(LO);
    for (int i = 0; i < 5; i++) @(negedge clk);
    send_n(0, WLEN - 61);
    chk("R8 gaps ignored, sel held", int'(sel), 2);
    chk("R7 matched held after good window", int'(matched), 1);
    send_n(0, WLEN);
    chk("R7 tally cleared, sel steps", int'(sel), 3);
    chk("R6 matched cleared", int'(matched), 0);
  endtask

  task automatic t_wrap();
    while (m_sel != (1 << SW) - 1) send_n(HI + 5, WLEN);
    chk("R9 sel at max", int'(sel), (1 << SW) - 1);
    send_n(HI + 5, WLEN);
    chk("R9 sel wraps to zero", int'(sel), 0);
    chk("R6 model agreement matched", int'(matched), int'(m_match));
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_dry_window();
    t_last_good();
    t_good_window();
    t_wrap();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule